// File: doc/BRIEF.md
# Double to signed integer converter

This unit turns one IEEE-754 binary64 operand into a signed two's-complement integer that is either 32 or 64 bits wide. It sits in an execution pipeline as a one-stage operation: operands and controls presented before a rising clock edge produce a registered result, an invalid flag and an inexact flag after that edge. The flags are reported only. Trapping, masking and writeback belong to the surrounding logic.

The rounding direction comes from a global 2-bit control field. A per-operation override, with its own enable, replaces that field for a single conversion. Any result that cannot be represented in the chosen width is not clamped. Instead the unit returns a fixed most-negative pattern and raises invalid. This applies to NaN, to either infinity, and to finite values whose rounded result falls out of range.

Top module: `dbl2int_cvt`

## Requirements
- R1: Outputs are registered. A result appears on the first rising edge after its inputs, and an active-low asynchronous reset clears res_o, invalid_o and inexact_o to 0.
- R2: The rounding mode in effect is rm_ovr_i when rm_ovr_en_i is 1, and rm_i otherwise. The encoding is 00 nearest-even, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero.
- R3: In mode 00, values with a nonzero fraction go to the nearest integer. An exact tie goes to the even neighbour, for both signs.
- R4: Mode 01 returns floor, mode 10 returns ceiling, and mode 11 truncates toward zero.
- R5: With wide_i=0 the result is a signed 32-bit integer in res_o[31:0], and res_o[63:32] is 0. A rounded result outside [-2^31, 2^31-1] gives invalid_o=1 and res_o=0x0000_0000_8000_0000.
- R6: With wide_i=1, a rounded result outside [-2^63, 2^63-1] gives invalid_o=1 and res_o=0x8000_0000_0000_0000.
- R7: A NaN or an infinity of either sign (exponent field all ones) gives invalid_o=1 and the indefinite pattern for the selected width, with inexact_o=0.
- R8: inexact_o is 1 exactly when the result is valid and nonzero fraction bits were discarded. It is never 1 together with invalid_o.
- R9: Zero of either sign gives 0 and no flags. A denormal is rounded like any tiny value: 0 under modes 00 and 11, and 1 or -1 only when the directed mode points away from zero. In every case inexact_o is 1.
- R10: Exactly -2^31 (32-bit) and -2^63 (64-bit) convert without invalid. The largest double below 2^63 converts validly in 64-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | binary64 source operand |
| wide_i | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| rm_i | input | 2 | Global rounding-mode field |
| rm_ovr_en_i | input | 1 | Enables the per-operation rounding override |
| rm_ovr_i | input | 2 | Per-operation rounding mode |
| res_o | output | 64 | Integer result (zero-extended in 32-bit mode) |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Precision (inexact) flag |

## Verification
Exact ties such as ±0.5, 2.5 and 3.5 are run under all four modes, together with near-ties like 2.4999. This separates nearest-even from half-up and from truncation, and shows that the override rather than the global field selects the mode. Values just inside and just outside each limit are included: 2^31-1 plus a fraction, -2^31-0.5, -2^31, 2^63, the largest double under 2^63, and -2^63. These show whether range is judged after rounding and whether the most-negative value is accepted. NaNs, infinities, signed zeros and denormals under every mode check the special paths, and a pseudo-random sweep of exponents around the integer boundary covers the shifter. Each result is compared against a real-number model on every clock.

// File: rtl/dbl2int_pkg.sv
package dbl2int_pkg;
  localparam int EXP_W    = 11;
  localparam int MAN_W    = 52;
  localparam int BIAS     = 1023;
  localparam int INT_W    = 64;
  localparam int NARROW_W = 32;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;
endpackage

// File: rtl/dbl2int_unpack.sv
module dbl2int_unpack
  import dbl2int_pkg::*;
#(
  parameter int EW   = EXP_W,
  parameter int MW   = MAN_W,
  parameter int BS   = BIAS,
  parameter int IW   = INT_W,
  localparam int SA_W = $clog2(IW + 1)
) (
  input  logic [EW+MW:0] src_i,
  output logic           sign_o,
  output logic           special_o,
  output logic           huge_o,
  output logic           tiny_o,
  output logic [MW:0]    mant_o,
  output logic [SA_W-1:0] shamt_o
);
  localparam int XW = EW + 2;
  localparam logic signed [XW-1:0] BIAS_V = XW'(BS);
  localparam logic signed [XW-1:0] LIM_V  = XW'(IW);
  localparam logic signed [XW-1:0] NEG1_V = -1;

  logic [EW-1:0] exp_f;
  logic [MW-1:0] frac_f;
  logic          exp_nz;
  logic signed [XW-1:0] exp_unb;
  logic signed [XW-1:0] exp_p1;

  assign sign_o = src_i[EW+MW];
  assign exp_f  = src_i[EW+MW-1:MW];
  assign frac_f = src_i[MW-1:0];
  assign exp_nz = |exp_f;

  // denormals share the exponent of the smallest normal
  always_comb begin
    exp_unb = $signed({2'b00, (exp_nz ? exp_f : EW'(1))}) - BIAS_V;
    exp_p1  = exp_unb + XW'(1);
  end

  assign special_o = &exp_f;
  assign mant_o    = {exp_nz, frac_f};
  assign huge_o    = !special_o && (exp_unb >= LIM_V);
  assign tiny_o    = exp_unb < NEG1_V;
  assign shamt_o   = (huge_o || tiny_o) ? '0 : exp_p1[SA_W-1:0];
endmodule

// File: rtl/dbl2int_align.sv
module dbl2int_align
  import dbl2int_pkg::*;
#(
  parameter int MW   = MAN_W,
  parameter int IW   = INT_W,
  localparam int SA_W = $clog2(IW + 1),
  localparam int SH_W = IW + MW + 1
) (
  input  logic [MW:0]     mant_i,
  input  logic [SA_W-1:0] shamt_i,
  input  logic            tiny_i,
  output logic [IW-1:0]   int_o,
  output logic            guard_o,
  output logic            sticky_o
);
  // mantissa MSB at weight 2^-1 when shamt is 0
  logic [SH_W-1:0] base;
  logic [SH_W-1:0] shifted;

  assign base    = {{IW{1'b0}}, mant_i};
  assign shifted = base << shamt_i;

  always_comb begin
    if (tiny_i) begin
      int_o    = '0;
      guard_o  = 1'b0;
      sticky_o = |mant_i;
    end else begin
      int_o    = shifted[SH_W-1:MW+1];
      guard_o  = shifted[MW];
      sticky_o = |shifted[MW-1:0];
    end
  end
endmodule

// File: rtl/dbl2int_round.sv
module dbl2int_round
  import dbl2int_pkg::*;
#(
  parameter int IW = INT_W
) (
  input  logic          sign_i,
  input  logic [1:0]    rm_i,
  input  logic          rm_ovr_en_i,
  input  logic [1:0]    rm_ovr_i,
  input  logic [IW-1:0] int_i,
  input  logic          guard_i,
  input  logic          sticky_i,
  output logic [IW:0]   mag_o,
  output logic          lost_o
);
  rmode_e mode;
  logic   inc;

  assign mode   = rmode_e'(rm_ovr_en_i ? rm_ovr_i : rm_i);
  assign lost_o = guard_i | sticky_i;

  always_comb begin
    unique case (mode)
      RM_NEAR: inc = guard_i & (sticky_i | int_i[0]);
      RM_DOWN: inc = sign_i & lost_o;
      RM_UP:   inc = !sign_i & lost_o;
      default: inc = 1'b0;
    endcase
  end

  assign mag_o = {1'b0, int_i} + {{IW{1'b0}}, inc};
endmodule

// File: rtl/dbl2int_range.sv
module dbl2int_range
  import dbl2int_pkg::*;
#(
  parameter int IW = INT_W,
  parameter int NW = NARROW_W
) (
  input  logic          sign_i,
  input  logic          wide_i,
  input  logic          special_i,
  input  logic          huge_i,
  input  logic [IW:0]   mag_i,
  input  logic          lost_i,
  output logic [IW-1:0] res_o,
  output logic          invalid_o,
  output logic          inexact_o
);
  logic [IW:0]   sgn;
  logic [1:0]    fits;
  logic [IW-1:0] val  [2];
  logic [IW-1:0] indef[2];

  assign sgn = sign_i ? (~mag_i + 1'b1) : mag_i;

  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int W = (g == 0) ? NW : IW;
    localparam logic [IW:0]   LIM  = {{IW{1'b0}}, 1'b1} << (W - 1);
    localparam logic [IW-1:0] MASK = {IW{1'b1}} >> (IW - W);
    assign fits[g]  = sign_i ? (mag_i <= LIM) : (mag_i < LIM);
    assign val[g]   = sgn[IW-1:0] & MASK;
    assign indef[g] = {{(IW-1){1'b0}}, 1'b1} << (W - 1);
  end

  always_comb begin
    invalid_o = special_i | huge_i | !fits[wide_i];
    res_o     = invalid_o ? indef[wide_i] : val[wide_i];
    inexact_o = !invalid_o & lost_i;
  end
endmodule

// File: rtl/dbl2int_cvt.sv
module dbl2int_cvt
  import dbl2int_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W,
  parameter int BS = BIAS,
  parameter int IW = INT_W,
  parameter int NW = NARROW_W,
  localparam int SA_W = $clog2(IW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EW+MW:0]   src_i,
  input  logic             wide_i,
  input  logic [1:0]       rm_i,
  input  logic             rm_ovr_en_i,
  input  logic [1:0]       rm_ovr_i,
  output logic [IW-1:0]    res_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  logic            sign, special, huge, tiny;
  logic [MW:0]     mant;
  logic [SA_W-1:0] shamt;
  logic [IW-1:0]   int_part;
  logic            guard, sticky, lost;
  logic [IW:0]     mag;
  logic [IW-1:0]   res_d;
  logic            inv_d, inx_d;

  dbl2int_unpack #(.EW(EW), .MW(MW), .BS(BS), .IW(IW)) u_unpack (
    .src_i    (src_i),
    .sign_o   (sign),
    .special_o(special),
    .huge_o   (huge),
    .tiny_o   (tiny),
    .mant_o   (mant),
    .shamt_o  (shamt)
  );

  dbl2int_align #(.MW(MW), .IW(IW)) u_align (
    .mant_i  (mant),
    .shamt_i (shamt),
    .tiny_i  (tiny),
    .int_o   (int_part),
    .guard_o (guard),
    .sticky_o(sticky)
  );

  dbl2int_round #(.IW(IW)) u_round (
    .sign_i     (sign),
    .rm_i       (rm_i),
    .rm_ovr_en_i(rm_ovr_en_i),
    .rm_ovr_i   (rm_ovr_i),
    .int_i      (int_part),
    .guard_i    (guard),
    .sticky_i   (sticky),
    .mag_o      (mag),
    .lost_o     (lost)
  );

  dbl2int_range #(.IW(IW), .NW(NW)) u_range (
    .sign_i    (sign),
    .wide_i    (wide_i),
    .special_i (special),
    .huge_i    (huge),
    .mag_i     (mag),
    .lost_i    (lost),
    .res_o     (res_d),
    .invalid_o (inv_d),
    .inexact_o (inx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      invalid_o <= inv_d;
      inexact_o <= inx_d;
    end
  end
endmodule

// File: rtl/dbl2int_cvt_chk.sv
module dbl2int_cvt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] src_i,
  input logic        wide_i,
  input logic [63:0] res_o,
  input logic        invalid_o,
  input logic        inexact_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_indef32_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && invalid_o && !$past(wide_i)) |-> (res_o == 64'h0000_0000_8000_0000));

  assert_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(wide_i)) |-> (res_o[63:32] == 32'h0));

  assert_indef64_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && invalid_o && $past(wide_i)) |-> (res_o == 64'h8000_0000_0000_0000));

  assert_special_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ($past(src_i[62:52]) == 11'h7FF)) |-> (invalid_o && !inexact_o));

  assert_flag_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !inexact_o);

  assert_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ($past(src_i[62:0]) == 63'h0)) |-> (res_o == 64'h0 && !invalid_o && !inexact_o));
endmodule

bind dbl2int_cvt dbl2int_cvt_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_i    (src_i),
  .wide_i   (wide_i),
  .res_o    (res_o),
  .invalid_o(invalid_o),
  .inexact_o(inexact_o)
);

// File: tb/sim_dbl2int_cvt.sv
`timescale 1ns/1ps
module sim_dbl2int_cvt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        wide = 1'b0;
  logic [1:0]  rm = 2'b00;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr = 2'b00;
  logic [63:0] res;
  logic        inv, inx;
  string       cur_tag = "R1";

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [63:0] res;
    logic        inv;
    logic        inx;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  dbl2int_cvt u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wide_i(wide),
    .rm_i(rm), .rm_ovr_en_i(ovr_en), .rm_ovr_i(ovr),
    .res_o(res), .invalid_o(inv), .inexact_o(inx)
  );

  localparam real P63 = 9223372036854775808.0;
  localparam real P31 = 2147483648.0;

  function automatic exp_t model(logic [63:0] v, logic w, logic [1:0] m, string tag);
    exp_t e;
    real x, fl, r, d;
    longint li;
    e.tag = tag;
    e.inx = 1'b0;
    if (v[62:52] == 11'h7FF) begin
      e.inv = 1'b1;
      e.res = w ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
      return e;
    end
    x  = $bitstoreal(v);
    fl = $floor(x);
    case (m)
      2'b00: begin
        d = x - fl;
        if (d > 0.5) r = fl + 1.0;
        else if (d < 0.5) r = fl;
        else r = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
      end
      2'b01: r = fl;
      2'b10: r = $ceil(x);
      default: r = (x < 0.0) ? $ceil(x) : fl;
    endcase
    if (w) e.inv = !(r >= -P63 && r < P63);
    else   e.inv = !(r >= -P31 && r < P31);
    if (e.inv) begin
      e.res = w ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
    end else begin
      li    = longint'(r);
      e.res = w ? 64'(li) : {32'h0, li[31:0]};
      e.inx = (r != x);
    end
    return e;
  endfunction

  // reference model: sample inputs on every rising edge
  always @(posedge clk) begin
    if (rst_n) exp_q.push_back(model(src, wide, ovr_en ? ovr : rm, cur_tag));
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (res !== e.res || inv !== e.inv || inx !== e.inx) begin
        failures++;
        $display("FAIL %s: got res=%h inv=%b inx=%b, expected res=%h inv=%b inx=%b",
                 e.tag, res, inv, inx, e.res, e.inv, e.inx);
      end
    end
  end

  task automatic put(logic [63:0] v, logic w, logic [1:0] m, string tag);
    @(negedge clk);
    src = v; wide = w; rm = m; ovr_en = 1'b0; ovr = ~m; cur_tag = tag;
  endtask

  task automatic put_ovr(logic [63:0] v, logic w, logic [1:0] g, logic en,
                         logic [1:0] o, string tag);
    @(negedge clk);
    src = v; wide = w; rm = g; ovr_en = en; ovr = o; cur_tag = tag;
  endtask

  task automatic all_modes(real x, string tag);
    for (int m = 0; m < 4; m++) begin
      put($realtobits(x), 1'b0, 2'(m), tag);
      put($realtobits(x), 1'b1, 2'(m), tag);
    end
  endtask

  initial begin
    #(20ns * 200000);
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset holds outputs at zero even with a NaN on the input
    src = 64'h7FF8_0000_0000_0000;
    wide = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (res !== 64'h0 || inv !== 1'b0 || inx !== 1'b0) begin
      failures++;
      $display("FAIL R1: got res=%h inv=%b inx=%b, expected all zero", res, inv, inx);
    end
    rst_n = 1'b1;

    // R3: ties and near-ties under nearest-even
    put($realtobits(2.5), 1'b1, 2'b00, "R3");
    put($realtobits(3.5), 1'b1, 2'b00, "R3");
    put($realtobits(-2.5), 1'b1, 2'b00, "R3");
    put($realtobits(0.5), 1'b0, 2'b00, "R3");
    put($realtobits(-0.5), 1'b0, 2'b00, "R3");
    put($realtobits(1.5), 1'b0, 2'b00, "R3");
    put($realtobits(2.4999), 1'b0, 2'b00, "R3");
    put($realtobits(-7.75), 1'b1, 2'b00, "R3");

    // R4: directed modes
    for (int m = 1; m < 4; m++) begin
      put($realtobits(2.5), 1'b1, 2'(m), "R4");
      put($realtobits(-2.5), 1'b0, 2'(m), "R4");
      put($realtobits(-0.25), 1'b1, 2'(m), "R4");
      put($realtobits(123456.875), 1'b0, 2'(m), "R4");
    end

    // R2: override selects the mode only when enabled
    put_ovr($realtobits(2.7), 1'b1, 2'b00, 1'b1, 2'b11, "R2");
    put_ovr($realtobits(2.7), 1'b1, 2'b11, 1'b0, 2'b00, "R2");
    put_ovr($realtobits(-2.2), 1'b0, 2'b10, 1'b1, 2'b01, "R2");
    put_ovr($realtobits(-2.2), 1'b0, 2'b01, 1'b1, 2'b10, "R2");

    // R5: 32-bit range after rounding
    put($realtobits(2147483647.4), 1'b0, 2'b00, "R5");
    put($realtobits(2147483647.5), 1'b0, 2'b00, "R5");
    put($realtobits(2147483647.9), 1'b0, 2'b11, "R5");
    put($realtobits(-2147483648.5), 1'b0, 2'b00, "R5");
    put($realtobits(-2147483648.5), 1'b0, 2'b01, "R5");
    put($realtobits(-2147483649.0), 1'b0, 2'b11, "R5");
    put($realtobits(1.0e10), 1'b0, 2'b00, "R5");
    put($realtobits(-5.0), 1'b0, 2'b00, "R5");

    // R6: 64-bit range
    put($realtobits(P63), 1'b1, 2'b00, "R6");
    put($realtobits(-9223372036854777856.0), 1'b1, 2'b10, "R6");
    put($realtobits(1.0e30), 1'b1, 2'b00, "R6");
    put($realtobits(-1.0e300), 1'b1, 2'b11, "R6");
    put($realtobits(4294967296.5), 1'b1, 2'b10, "R6");

    // R7: NaN and infinities in both widths
    for (int w = 0; w < 2; w++) begin
      put(64'h7FF0_0000_0000_0000, 1'(w), 2'b00, "R7");
      put(64'hFFF0_0000_0000_0000, 1'(w), 2'b01, "R7");
      put(64'h7FF8_0000_0000_0000, 1'(w), 2'b10, "R7");
      put(64'hFFF0_0000_0000_0001, 1'(w), 2'b11, "R7");
    end

    // R8: exact and inexact values
    put($realtobits(3.0), 1'b0, 2'b00, "R8");
    put($realtobits(1.25), 1'b0, 2'b10, "R8");
    put($realtobits(1152921504606846976.0), 1'b1, 2'b00, "R8");
    put($realtobits(4503599627370497.0), 1'b1, 2'b01, "R8");

    // R9: zeros and denormals under every mode
    for (int m = 0; m < 4; m++) begin
      put(64'h0000_0000_0000_0000, 1'b1, 2'(m), "R9");
      put(64'h8000_0000_0000_0000, 1'b0, 2'(m), "R9");
      put(64'h0000_0000_0000_0001, 1'b1, 2'(m), "R9");
      put(64'h8000_0000_0000_0001, 1'b0, 2'(m), "R9");
      put(64'h000F_FFFF_FFFF_FFFF, 1'b1, 2'(m), "R9");
    end

    // R10: most-negative values and the top finite double below 2^63
    all_modes(-2147483648.0, "R10");
    put($realtobits(-P63), 1'b1, 2'b00, "R10");
    put($realtobits(-P63), 1'b1, 2'b10, "R10");
    put($realtobits(9223372036854774784.0), 1'b1, 2'b00, "R10");

    // R4: sweep of exponents around the integer boundary
    for (int i = 0; i < 400; i++) begin
      logic [63:0] v;
      logic [10:0] e;
      e = 11'(1000 + ($urandom % 90));
      v = {1'($urandom), e, 20'($urandom), 32'($urandom)};
      put(v, 1'($urandom), 2'($urandom), "R4");
    end

    put(64'h0, 1'b0, 2'b00, "R9");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule